// File: doc/BRIEF.md
# Debounced Command/Indication Code Port

This block moves a short command/indication code between two protocol layers that share a frame-based serial bus, where each frame carries one code slot in each direction. The framing logic around it hands over the received slot value together with a one-cycle frame strobe. In return it takes the transmit slot value, which the block holds steady for the whole frame.

On the receive side a code that differs from the currently accepted one is taken only after it has been seen at two frame strobes in a row, so a single corrupted frame cannot cause a false change. Accepted codes pass through a two-entry queue. The front entry is what the host sees in its status register, together with a change flag. Reading the status register frees the front entry. If a second code is already waiting, it moves forward at that read and raises the interrupt again. On the transmit side the host writes a code, and the block presents that code in every frame from the next frame strobe onward until the host writes again.

Top module: `cmd_ind_port`

## Requirements
- R1: After reset, `stat_code` and `tx_code` are 4'b1111, `stat_chg` is 0 and `irq` is 0.
- R2: A received code that differs from the accepted code is accepted at the second of two consecutive frame strobes carrying that same value. It then appears on `stat_code` with `stat_chg` = 1 in the cycle after that strobe edge.
- R3: A differing code seen at only one strobe is not accepted. This holds whether the next strobe brings back the accepted code or brings a different new value.
- R4: `rx_code` is sampled only in cycles where `frame_stb` is 1. Values present in other cycles have no effect on acceptance.
- R5: Each time a code is loaded into the status register, `stat_chg` is set and `irq` is high for the cycle that follows the loading edge.
- R6: A host read (`host_stat_rd` = 1 for one cycle) with no second code queued clears `stat_chg` and leaves `stat_code` unchanged.
- R7: If a second code is accepted before the first is read, `stat_code` keeps the first code. The read then loads the second code into `stat_code`, keeps `stat_chg` = 1 and pulses `irq` in the next cycle.
- R8: A code accepted while both queue entries are full replaces the waiting entry, and the front entry stays unchanged.
- R9: When a host read and an acceptance fall in the same cycle, neither is lost. The read frees the front entry, and the newly accepted code is loaded and flagged.
- R10: A host write of `host_tx_data` shows on `tx_code` from the next frame strobe edge on, and `tx_code` changes only at frame strobe edges.
- R11: Receiving the currently accepted code at any number of strobes never sets `stat_chg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking the code slot of a frame |
| rx_code | input | 4 | Received slot code, valid with `frame_stb` |
| tx_code | output | 4 | Code presented for the transmit slot |
| host_tx_wr | input | 1 | Host write strobe for the transmit code |
| host_tx_data | input | 4 | Transmit code written by the host |
| host_stat_rd | input | 1 | One-cycle host read of the status register |
| stat_code | output | 4 | Status register code (front queue entry) |
| stat_chg | output | 1 | Unread change flag |
| irq | output | 1 | Interrupt pulse, one cycle per code loaded |

## Verification
Two functions can land in the same cycle: a host status read, and the second confirming frame strobe of a new code. The bench makes them coincide by first accepting one code, sending a single strobe of another code, and then raising the read together with that code's confirming strobe on the same clock edge. The bench judges the result by sampling the status before the edge, which must still show the first code. After the edge it must show the new code with the change flag set and an interrupt pulse, and a follow-up read must clear the flag.

// File: rtl/cmdci_pkg.sv
package cmdci_pkg;
   localparam int unsigned CI_W_DEF     = 4;
   localparam int unsigned CI_CONFIRM_1 = 1;
   localparam int unsigned CI_CONFIRM_2 = 2;
endpackage

// File: rtl/cmdci_debounce.sv
module cmdci_debounce #(
   parameter int unsigned  W        = cmdci_pkg::CI_W_DEF,
   parameter int unsigned  CONFIRM  = cmdci_pkg::CI_CONFIRM_2,
   parameter logic [W-1:0] RST_CODE = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb_i,
   input  logic [W-1:0] code_i,
   output logic         accept_o,
   output logic [W-1:0] code_o
);
   logic [W-1:0] acc_q;
   logic         differs;

   assign differs = stb_i && (code_i != acc_q);
   assign code_o  = code_i;

   generate
      if (CONFIRM == cmdci_pkg::CI_CONFIRM_1) begin : g_single
         assign accept_o = differs;
      end else begin : g_double
         logic [W-1:0] cand_q;
         logic         cand_v;
         logic [W-1:0] seen_q;
         logic         seen_v;

         assign accept_o = differs && cand_v && (cand_q == code_i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand_q <= RST_CODE;
               cand_v <= 1'b0;
            end else if (stb_i) begin
               if (differs && !accept_o) begin
                  cand_q <= code_i;
                  cand_v <= 1'b1;
               end else begin
                  cand_v <= 1'b0;
               end
            end
         end

         // independent record of the last strobed sample, used only by the check below
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= RST_CODE;
               seen_v <= 1'b0;
            end else if (stb_i) begin
               seen_q <= code_i;
               seen_v <= 1'b1;
            end
         end

         p_two_sightings_r2: assert property (@(posedge clk) disable iff (!rst_n)
            accept_o |-> (seen_v && seen_q == code_i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= RST_CODE;
      else if (accept_o) acc_q <= code_i;
   end

   p_sample_on_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(acc_q));

   p_same_code_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && code_i == acc_q) |-> !accept_o);
endmodule

// File: rtl/cmdci_queue.sv
module cmdci_queue #(
   parameter int unsigned  W        = cmdci_pkg::CI_W_DEF,
   parameter logic [W-1:0] RST_CODE = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] push_code_i,
   input  logic         rd_i,
   output logic [W-1:0] shown_o,
   output logic         chg_o,
   output logic         irq_o
);
   logic [W-1:0] shown_q, pend_q, n_shown, n_pend;
   logic         chg_q, pend_v, n_chg, n_pend_v, load;

   always_comb begin
      n_shown  = shown_q;
      n_chg    = chg_q;
      n_pend   = pend_q;
      n_pend_v = pend_v;
      load     = 1'b0;
      if (rd_i && chg_q) begin
         if (pend_v) begin
            n_shown  = pend_q;
            n_pend_v = 1'b0;
            load     = 1'b1;
         end else begin
            n_chg = 1'b0;
         end
      end
      if (push_i) begin
         if (!n_chg) begin
            n_shown = push_code_i;
            n_chg   = 1'b1;
            load    = 1'b1;
         end else begin
            n_pend   = push_code_i;
            n_pend_v = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shown_q <= RST_CODE;
         chg_q   <= 1'b0;
         pend_q  <= RST_CODE;
         pend_v  <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         shown_q <= n_shown;
         chg_q   <= n_chg;
         pend_q  <= n_pend;
         pend_v  <= n_pend_v;
         irq_o   <= load;
      end
   end

   assign shown_o = shown_q;
   assign chg_o   = chg_q;

   p_irq_with_chg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> chg_q);

   p_clear_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_q && !rd_i) |=> chg_q);

   p_pop_reraises_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && chg_q && pend_v) |=> (chg_q && irq_o));

   p_head_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_q && !rd_i) |=> $stable(shown_q));

   p_collide_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && push_i) |=> chg_q);
endmodule

// File: rtl/cmdci_txreg.sv
module cmdci_txreg #(
   parameter int unsigned  W        = cmdci_pkg::CI_W_DEF,
   parameter logic [W-1:0] RST_CODE = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         stb_i,
   output logic [W-1:0] slot_o
);
   logic [W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RST_CODE;
         slot_o <= RST_CODE;
      end else begin
         if (wr_i)  hold_q <= wdata_i;
         if (stb_i) slot_o <= hold_q;
      end
   end

   p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(slot_o));
endmodule

// File: rtl/cmd_ind_port.sv
module cmd_ind_port #(
   parameter int unsigned       CODE_W         = cmdci_pkg::CI_W_DEF,
   parameter int unsigned       CONFIRM_FRAMES = cmdci_pkg::CI_CONFIRM_2,
   parameter logic [CODE_W-1:0] IDLE_CODE      = {CODE_W{1'b1}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [CODE_W-1:0] rx_code,
   output logic [CODE_W-1:0] tx_code,
   input  logic              host_tx_wr,
   input  logic [CODE_W-1:0] host_tx_data,
   input  logic              host_stat_rd,
   output logic [CODE_W-1:0] stat_code,
   output logic              stat_chg,
   output logic              irq
);
   initial begin
      a_width_ok: assert (CODE_W >= 1 && CODE_W <= 16);
      a_confirm_ok: assert (CONFIRM_FRAMES == cmdci_pkg::CI_CONFIRM_1 ||
                            CONFIRM_FRAMES == cmdci_pkg::CI_CONFIRM_2);
   end

   logic              accept;
   logic [CODE_W-1:0] accept_code;

   cmdci_debounce #(.W(CODE_W), .CONFIRM(CONFIRM_FRAMES), .RST_CODE(IDLE_CODE)) u_deb (
      .clk(clk), .rst_n(rst_n), .stb_i(frame_stb), .code_i(rx_code),
      .accept_o(accept), .code_o(accept_code));

   cmdci_queue #(.W(CODE_W), .RST_CODE(IDLE_CODE)) u_q (
      .clk(clk), .rst_n(rst_n), .push_i(accept), .push_code_i(accept_code),
      .rd_i(host_stat_rd), .shown_o(stat_code), .chg_o(stat_chg), .irq_o(irq));

   cmdci_txreg #(.W(CODE_W), .RST_CODE(IDLE_CODE)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_i(host_tx_wr), .wdata_i(host_tx_data),
      .stb_i(frame_stb), .slot_o(tx_code));
endmodule

// File: tb/cmd_ind_port_test.sv
module cmd_ind_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic [3:0] rx_code = 4'hF;
   logic [3:0] tx_code;
   logic       host_tx_wr = 1'b0;
   logic [3:0] host_tx_data = 4'h0;
   logic       host_stat_rd = 1'b0;
   logic [3:0] stat_code;
   logic       stat_chg;
   logic       irq;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   cmd_ind_port uut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_code(rx_code),
      .tx_code(tx_code), .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
      .host_stat_rd(host_stat_rd), .stat_code(stat_code), .stat_chg(stat_chg), .irq(irq));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic strobe(input logic [3:0] c);
      @(negedge clk);
      rx_code = c; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   // drives a one-cycle read; returns the value seen by the host
   task automatic host_read(output logic [3:0] seen);
      @(negedge clk);
      seen = stat_code;
      host_stat_rd = 1'b1;
      @(negedge clk);
      host_stat_rd = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "stat_code", stat_code, 4'hF);
      chk("R1", "tx_code", tx_code, 4'hF);
      chk("R1", "stat_chg", stat_chg, 0);
      chk("R1", "irq", irq, 0);
   endtask

   task automatic t_accept;
      logic [3:0] s;
      strobe(4'h5);
      chk("R2", "chg after one sighting", stat_chg, 0);
      strobe(4'h5);
      chk("R2", "stat_code after two", stat_code, 4'h5);
      chk("R5", "chg set", stat_chg, 1);
      chk("R5", "irq pulse", irq, 1);
      @(negedge clk);
      chk("R5", "irq one cycle", irq, 0);
      host_read(s);
      chk("R6", "read value", s, 4'h5);
      chk("R6", "chg cleared", stat_chg, 0);
      chk("R6", "code kept", stat_code, 4'h5);
   endtask

   task automatic t_glitch;
      logic [3:0] s;
      strobe(4'h3); strobe(4'h5); strobe(4'h3);
      chk("R3", "glitch back to accepted", stat_chg, 0);
      strobe(4'h9); strobe(4'hA);
      chk("R3", "two different new values", stat_chg, 0);
      strobe(4'hA);
      chk("R3", "later confirmed code", stat_code, 4'hA);
      host_read(s);
   endtask

   task automatic t_between;
      @(negedge clk);
      rx_code = 4'h7;
      repeat (4) @(negedge clk);
      strobe(4'h7);
      chk("R4", "off-strobe value ignored", stat_chg, 0);
      strobe(4'hA);
      chk("R4", "code unchanged", stat_code, 4'hA);
   endtask

   task automatic t_queue;
      logic [3:0] s;
      strobe(4'h1); strobe(4'h1);
      strobe(4'h2); strobe(4'h2);
      chk("R7", "front kept before read", stat_code, 4'h1);
      host_read(s);
      chk("R7", "first read value", s, 4'h1);
      chk("R7", "second code shown", stat_code, 4'h2);
      chk("R7", "chg kept", stat_chg, 1);
      chk("R7", "irq re-raised", irq, 1);
      host_read(s);
      chk("R7", "chg cleared after second", stat_chg, 0);
   endtask

   task automatic t_overwrite;
      logic [3:0] s;
      strobe(4'h4); strobe(4'h4);
      strobe(4'h6); strobe(4'h6);
      strobe(4'h8); strobe(4'h8);
      chk("R8", "front entry kept", stat_code, 4'h4);
      host_read(s);
      chk("R8", "newest replaced waiting", stat_code, 4'h8);
      host_read(s);
      chk("R8", "queue empty", stat_chg, 0);
   endtask

   task automatic t_collide;
      logic [3:0] s;
      strobe(4'hC); strobe(4'hC);
      strobe(4'hD);
      @(negedge clk);
      s = stat_code;
      rx_code = 4'hD; frame_stb = 1'b1; host_stat_rd = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0; host_stat_rd = 1'b0;
      chk("R9", "read value", s, 4'hC);
      chk("R9", "new code loaded", stat_code, 4'hD);
      chk("R9", "chg set", stat_chg, 1);
      chk("R9", "irq", irq, 1);
      host_read(s);
      chk("R9", "cleared by next read", stat_chg, 0);
   endtask

   task automatic t_tx;
      @(negedge clk);
      host_tx_wr = 1'b1; host_tx_data = 4'h6;
      @(negedge clk);
      host_tx_wr = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10", "no change before strobe", tx_code, 4'hF);
      strobe(4'hD);
      chk("R10", "new code after strobe", tx_code, 4'h6);
      @(negedge clk);
      host_tx_wr = 1'b1; host_tx_data = 4'h3;
      @(negedge clk);
      host_tx_wr = 1'b0;
      chk("R10", "held between frames", tx_code, 4'h6);
      strobe(4'hD);
      chk("R10", "second write sent", tx_code, 4'h3);
      strobe(4'hD);
      chk("R10", "repeated every frame", tx_code, 4'h3);
   endtask

   task automatic t_same;
      strobe(4'hD); strobe(4'hD); strobe(4'hD);
      chk("R11", "repeat of accepted code", stat_chg, 0);
      chk("R11", "irq quiet", irq, 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_accept();
      t_glitch();
      t_between();
      t_queue();
      t_overwrite();
      t_collide();
      t_tx();
      t_same();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end
endmodule